// File: doc/BRIEF.md
# Manchester Telegram Receiver with Pause Synchronisation

This block receives short telegrams on a single serial line that idles high and carries an active-low Manchester-II code. It runs from an oversampling system clock whose frequency is a parameter (8 MHz by default), and every time value is rounded to whole clock cycles. A falling edge on the idle line starts reception. A bit cell timer then takes two samples per 6 µs cell and decodes one bit per cell. The block checks the framing, the Manchester coding and the parity of each telegram.

A telegram is accepted only when the line then stays high for a minimum pause. That pause is short while the receiver is in its synchronous state and long while it is in its asynchronous state. On acceptance the block places the eleven data bits on its output and raises a 500 ns strobe. The strobe comes at a fixed delay after the end bit's rising edge, and that delay also depends on the state. Any fault produces a one-cycle error pulse and forces the asynchronous state. The receiver then ignores the line until it sees a long idle pause.

Top module: `mrx_rx`

## Requirements
- R1: After reset, rx_strobe, rx_error and rx_sync are 0 and rx_data is all zeros.
- R2: A telegram has 14 cells of 6 µs: a start bit (0), 11 data bits, a parity bit and an end bit (1). A 0 is low for the first half of its cell and high for the second. A 1 is high then low. The first data bit received appears on rx_data[10] and the last on rx_data[0].
- R3: An accepted telegram raises rx_strobe for exactly 500 ns (4 cycles at 8 MHz). rx_data changes only in the cycle the strobe rises and otherwise holds its value, including across rejected telegrams.
- R4: The strobe rises 9.5–10.0 µs after the end bit's rising edge in the synchronous state, and 21.0–21.5 µs after it in the asynchronous state.
- R5: After the end bit, the line must stay high for more than 6.0 µs (synchronous) or more than 18.0 µs (asynchronous). A low level earlier than that rejects the telegram with an error. A low level after that point does not prevent the strobe.
- R6: Parity is even over the eleven data bits plus the parity bit. A mismatch gives an error pulse and no strobe.
- R7: An end bit that decodes as 0 gives an error and no strobe.
- R8: A cell with no mid-cell transition (both halves at the same level) is a Manchester violation and gives an error and no strobe.
- R9: An error is a single-cycle rx_error pulse that clears rx_sync. No telegram is received until the line has been high continuously for more than 18 µs.
- R10: rx_sync becomes 1 when a strobe is produced and stays 1 until an error occurs.
- R11: A telegram that stops early, so that the line stays high during reception, gives an error and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idles high, active-low Manchester code |
| rx_data | output | 11 | Data bits of the last accepted telegram |
| rx_strobe | output | 1 | High for 500 ns when a telegram is accepted |
| rx_error | output | 1 | One-cycle pulse on any telegram fault |
| rx_sync | output | 1 | 1 in the synchronous state, 0 in the asynchronous state |

## Verification
A wrong synchronous/asynchronous state is visible on the next good telegram. The strobe then lands about 11.5 µs outside its window, and a pause that should have been rejected is accepted instead, or the reverse. A bit counter or cell timer that slips produces an error pulse within one or two cells, or wrong data at the next strobe. A strobe of the wrong width, or data that changes outside a strobe, shows up in the very cycle it happens. Directed telegrams cover both states, each kind of fault, each pause threshold and the recovery pause, and the bench measures strobe delay and width in clock cycles.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_ENDW,
        S_PAUSE,
        S_STB,
        S_WAITP
    } rx_state_e;

    // Nanoseconds to clock cycles, rounded to nearest.
    function automatic int ns2cyc(input longint hz, input longint ns);
        return int'((hz * ns + 64'd500_000_000) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/mrx_line.sv
// Line conditioner: input register, falling-edge detect, high-run counter.
module mrx_line #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    output logic          lvl,
    output logic          fall,
    output logic [CW-1:0] hi_run
);

    typedef struct packed {
        logic          s;
        logic          p;
        logic [CW-1:0] hi;
    } line_t;

    line_t q, d;

    always_comb begin
        d   = q;
        d.s = din;
        d.p = q.s;
        if (!q.s)
            d.hi = '0;
        else if (q.hi != '1)
            d.hi = q.hi + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{s: 1'b1, p: 1'b1, hi: '0};
        else
            q <= d;
    end

    assign lvl    = q.s;
    assign fall   = q.p & ~q.s;
    assign hi_run = q.hi;

endmodule

// File: rtl/mrx_cell.sv
// Bit cell timer: samples at one and three quarters of each cell.
module mrx_cell #(
    parameter int BIT_C = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic lvl,
    output logic tick,
    output logic val,
    output logic bad
);

    localparam int CNW = $clog2(BIT_C);
    localparam int Q1  = BIT_C / 4;
    localparam int Q3  = (3 * BIT_C) / 4;

    typedef struct packed {
        logic [CNW-1:0] cnt;
        logic           h1;
    } cell_t;

    cell_t q, d;

    always_comb begin
        d = q;
        if (go || q.cnt == CNW'(BIT_C - 1))
            d.cnt = '0;
        else
            d.cnt = q.cnt + 1'b1;
        if (q.cnt == CNW'(Q1))
            d.h1 = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{cnt: '0, h1: 1'b1};
        else
            q <= d;
    end

    assign tick = (q.cnt == CNW'(Q3));
    assign val  = q.h1;
    assign bad  = (q.h1 == lvl);

endmodule

// File: rtl/mrx_rx.sv
module mrx_rx #(
    parameter longint CLK_HZ = 8_000_000,
    parameter int     DBITS  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    output logic [DBITS-1:0] rx_data,
    output logic             rx_strobe,
    output logic             rx_error,
    output logic             rx_sync
);
    import mrx_pkg::*;

    localparam int BIT_C   = ns2cyc(CLK_HZ, 6000);
    localparam int INACT_C = ns2cyc(CLK_HZ, 7000);
    localparam int PS_C    = ns2cyc(CLK_HZ, 6000);
    localparam int PA_C    = ns2cyc(CLK_HZ, 18000);
    localparam int DS_C    = ns2cyc(CLK_HZ, 9750);
    localparam int DA_C    = ns2cyc(CLK_HZ, 21250);
    localparam int SW_C    = ns2cyc(CLK_HZ, 500);
    localparam int NB      = DBITS + 3;
    localparam int CW      = $clog2(DA_C + PA_C + INACT_C + BIT_C + SW_C + 4);
    localparam int IW      = $clog2(NB + 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CW-1:0]    tc;
        logic [IW-1:0]    idx;
        logic [DBITS-1:0] sh;
        logic             par;
        logic [DBITS-1:0] dat;
        logic             stb;
        logic             err;
        logic             syn;
    } rx_t;

    rx_t q, d;

    logic          lvl, fall, tick, val, bad, go, fail;
    logic [CW-1:0] hi_run;
    logic [CW-1:0] pth, dly;

    mrx_line #(.CW(CW)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (rx_line),
        .lvl    (lvl),
        .fall   (fall),
        .hi_run (hi_run)
    );

    mrx_cell #(.BIT_C(BIT_C)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .lvl   (lvl),
        .tick  (tick),
        .val   (val),
        .bad   (bad)
    );

    assign pth = q.syn ? CW'(PS_C) : CW'(PA_C);
    assign dly = q.syn ? CW'(DS_C - 2) : CW'(DA_C - 2);

    always_comb begin
        d     = q;
        d.err = 1'b0;
        go    = 1'b0;
        fail  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (fall) begin
                    d.st  = S_RECV;
                    d.idx = '0;
                    d.par = 1'b0;
                    go    = 1'b1;
                end
            end
            S_RECV: begin
                if (hi_run > CW'(INACT_C)) begin
                    fail = 1'b1;            // no activity inside a frame (R11)
                end else if (tick) begin
                    d.idx = q.idx + 1'b1;
                    if (bad) begin
                        fail = 1'b1;        // Manchester violation (R8)
                    end else if (q.idx == '0) begin
                        if (val) fail = 1'b1;
                    end else if (q.idx <= IW'(DBITS)) begin
                        d.sh  = {q.sh[DBITS-2:0], val};
                        d.par = q.par ^ val;
                    end else if (q.idx == IW'(DBITS + 1)) begin
                        if (q.par ^ val) fail = 1'b1;   // even parity (R6)
                    end else if (!val) begin
                        fail = 1'b1;        // end bit must be 1 (R7)
                    end else begin
                        d.st = S_ENDW;
                        d.tc = '0;
                    end
                end
            end
            S_ENDW: begin
                if (lvl) begin
                    d.st = S_PAUSE;
                    d.tc = '0;
                end else if (q.tc > CW'(BIT_C / 2)) begin
                    fail = 1'b1;
                end else begin
                    d.tc = q.tc + 1'b1;
                end
            end
            S_PAUSE: begin
                if (!lvl && q.tc < pth) begin
                    fail = 1'b1;            // pause too short (R5)
                end else if (q.tc == dly) begin
                    d.st  = S_STB;
                    d.tc  = '0;
                    d.stb = 1'b1;
                    d.dat = q.sh;
                    d.syn = 1'b1;
                end else begin
                    d.tc = q.tc + 1'b1;
                end
            end
            S_STB: begin
                if (q.tc == CW'(SW_C - 1)) begin
                    d.st  = S_IDLE;
                    d.stb = 1'b0;
                end else begin
                    d.tc = q.tc + 1'b1;
                end
            end
            S_WAITP: begin
                if (hi_run >= CW'(PA_C))
                    d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
        if (fail) begin
            d.st  = S_WAITP;
            d.err = 1'b1;
            d.syn = 1'b0;
            d.stb = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{st: S_IDLE, tc: '0, idx: '0, sh: '0, par: 1'b0,
                   dat: '0, stb: 1'b0, err: 1'b0, syn: 1'b0};
        else
            q <= d;
    end

    assign rx_data   = q.dat;
    assign rx_strobe = q.stb;
    assign rx_error  = q.err;
    assign rx_sync   = q.syn;

endmodule

// File: rtl/mrx_rx_chk.sv
module mrx_rx_chk #(
    parameter longint CLK_HZ = 8_000_000,
    parameter int     DBITS  = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DBITS-1:0] rx_data,
    input logic             rx_strobe,
    input logic             rx_error,
    input logic             rx_sync
);
    localparam int SW_C = mrx_pkg::ns2cyc(CLK_HZ, 500);
    localparam int WW   = $clog2(SW_C + 2);

    logic [WW-1:0] w_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            w_q <= '0;
        else if (rx_strobe)
            w_q <= w_q + 1'b1;
        else
            w_q <= '0;
    end

    p_strobe_not_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> (w_q < WW'(SW_C)));

    p_strobe_full_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_strobe) |-> (w_q == WW'(SW_C)));

    p_data_only_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(rx_strobe));

    p_sync_with_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_strobe) |-> rx_sync);

    p_sync_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_sync) |-> $rose(rx_strobe));

    p_error_clears_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |-> !rx_sync);

    p_error_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |=> !rx_error);

    p_no_strobe_on_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |-> !rx_strobe);

endmodule

bind mrx_rx mrx_rx_chk #(.CLK_HZ(CLK_HZ), .DBITS(DBITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_strobe (rx_strobe),
    .rx_error  (rx_error),
    .rx_sync   (rx_sync)
);

// File: tb/mrx_rx_test.sv
module mrx_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic [10:0] rx_data;
    logic        rx_strobe, rx_error, rx_sync;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_stb    = 0;
    int n_err    = 0;
    int stb_at   = 0;
    int run_w    = 0;
    int last_w   = 0;
    int t_rise   = 0;
    logic        stb_prev = 1'b0;
    logic [10:0] last_ok = '0;

    localparam int HALF = 24;    // half cell at 8 MHz

    mrx_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .rx_data   (rx_data),
        .rx_strobe (rx_strobe),
        .rx_error  (rx_error),
        .rx_sync   (rx_sync)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_strobe && !stb_prev) begin
                n_stb  = n_stb + 1;
                stb_at = cyc;
            end
            if (rx_strobe)
                run_w = run_w + 1;
            else if (stb_prev) begin
                last_w = run_w;
                run_w  = 0;
            end
            if (rx_error) n_err = n_err + 1;
        end
        stb_prev = rx_strobe;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input longint act,
                           input longint lo, input longint hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic drive_half(input logic v);
        rx_line = v;
        repeat (HALF) @(negedge clk);
    endtask

    // viol: cell index driven low for the whole cell (-1 = none); nb: cells sent
    task automatic tx_frame(input logic [10:0] dv, input bit bad_par, input bit bad_end,
                            input int viol, input int nb);
        logic [13:0] f;
        f[13] = 1'b0;
        for (int i = 0; i < 11; i++) f[12 - i] = dv[10 - i];
        f[1] = (^dv) ^ bad_par;
        f[0] = bad_end ? 1'b0 : 1'b1;
        for (int c = 0; c < nb; c++) begin
            if (c == viol) begin
                drive_half(1'b0);
                drive_half(1'b0);
            end else if (f[13 - c]) begin
                drive_half(1'b1);
                drive_half(1'b0);
            end else begin
                drive_half(1'b0);
                drive_half(1'b1);
            end
        end
        rx_line = 1'b1;
        t_rise  = cyc;
    endtask

    task automatic tail(input int low_at);
        if (low_at > 0) begin
            repeat (low_at) @(negedge clk);
            rx_line = 1'b0;
            repeat (HALF) @(negedge clk);
            rx_line = 1'b1;
        end
        repeat (400) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 strobe after reset", rx_strobe, 0);
        chk("R1 error after reset", rx_error, 0);
        chk("R1 sync after reset", rx_sync, 0);
        chk("R1 data after reset", rx_data, 0);
    endtask

    task automatic t_good(input logic [10:0] dv);
        int s0 = n_stb;
        int e0 = n_err;
        bit was_sync = rx_sync;
        tx_frame(dv, 0, 0, -1, 14);
        tail(0);
        chk("R3 one strobe", n_stb - s0, 1);
        chk("R3 no error", n_err - e0, 0);
        if (was_sync)
            chk_rng("R4 sync strobe delay", stb_at - t_rise, 76, 80);
        else
            chk_rng("R4 async strobe delay", stb_at - t_rise, 168, 172);
        chk("R3 strobe width", last_w, 4);
        chk("R2 data bits", rx_data, dv);
        chk("R10 sync after strobe", rx_sync, 1);
        last_ok = dv;
    endtask

    task automatic t_reject(input string tag, input logic [10:0] dv, input bit bad_par,
                            input bit bad_end, input int viol, input int nb, input int low_at);
        int s0 = n_stb;
        int e0 = n_err;
        tx_frame(dv, bad_par, bad_end, viol, nb);
        tail(low_at);
        chk({tag, " no strobe"}, n_stb - s0, 0);
        chk({tag, " one error"}, n_err - e0, 1);
        chk("R9 sync cleared", rx_sync, 0);
        chk("R3 data held", rx_data, last_ok);
    endtask

    task automatic t_late_low(input logic [10:0] dv);
        int s0 = n_stb;
        int e0 = n_err;
        tx_frame(dv, 0, 0, -1, 14);
        tail(80);
        chk("R5 late low keeps strobe", n_stb - s0, 1);
        chk("R5 late low no error", n_err - e0, 0);
        chk("R5 late low data", rx_data, dv);
        last_ok = dv;
    endtask

    task automatic t_ignore;
        int s0 = n_stb;
        int e0 = n_err;
        tx_frame(11'h321, 1, 0, -1, 14);
        repeat (40) @(negedge clk);
        tx_frame(11'h0AB, 0, 0, -1, 14);
        tail(0);
        chk("R9 frame during recovery ignored", n_stb - s0, 0);
        chk("R9 single error", n_err - e0, 1);
        chk("R9 data unchanged", rx_data, last_ok);
        chk("R9 still async", rx_sync, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_good(11'h5A3);
        t_good(11'h0F1);
        t_good(11'h7FF);
        t_good(11'h000);
        t_reject("R6 parity", 11'h123, 1, 0, -1, 14, 0);
        t_good(11'h2C4);
        t_reject("R5 sync short pause", 11'h2AA, 0, 0, -1, 14, 32);
        t_reject("R5 async short pause", 11'h155, 0, 0, -1, 14, 96);
        t_good(11'h155);
        t_late_low(11'h3C0);
        t_reject("R7 end bit", 11'h3A9, 0, 1, -1, 14, 0);
        t_good(11'h401);
        t_reject("R8 violation", 11'h0F0, 0, 0, 5, 14, 0);
        t_good(11'h1E7);
        t_reject("R11 truncated", 11'h6B2, 0, 0, -1, 5, 0);
        t_good(11'h013);
        t_ignore();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule